// File: doc/BRIEF.md
# Debug Trigger Mode Sequencer

This block decides when a debug trigger event occurs. It takes two comparator match pulses, A and B, which arrive already qualified and last one cycle each. A 4-bit mode field chooses the rule that turns those pulses into a trigger. The sequencer keeps an arm bit, which software sets and clears with one-cycle pulses. It keeps three sticky status flags: A, B, and C, where C records that the trigger fired. When the trigger fires it raises a one-cycle trigger pulse. In end-trigger operation it also raises a one-cycle disarm pulse and drops its own arm bit, so that trace capture stops at the event.

Matches count only while the arm bit and the global debug enable are both high, and only until the trigger has fired once. Setting the arm bit starts a fresh capture: all three flags clear and the block may fire again. The mode field has room for nine selectors. Three of them have behaviour: A only, A or B, and A then B. All other encodings behave as A only.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset, every output is 0.
- R2: A cycle with arm_set_i=1 and arm_clr_i=0 makes arm_o 1 on the next cycle and clears flags A, B and C. A cycle with arm_clr_i=1 makes arm_o 0 on the next cycle and leaves the flags unchanged. When both are high, the clear wins.
- R3: A match pulse has no effect unless arm_o=1 and dbg_en_i=1 in that cycle. Without both, no flag is set and no trigger fires.
- R4: With mode_i=0 (A only), a match on A sets flag A, and trig_o rises on the next cycle. A match on B is ignored and flag B stays 0.
- R5: With mode_i=1 (A or B), a match on either comparator sets its own flag, and trig_o rises on the next cycle.
- R6: With mode_i=2 (A then B), a match on A sets flag A and does not trigger. A match on B is ignored while flag A is 0. A match on B after flag A is set sets flag B, and trig_o rises on the next cycle.
- R7: With mode_i=2, if A and B match in the same cycle while flag A is 0, only flag A is set. A later B match is needed to trigger.
- R8: trig_o stays high for exactly one cycle. Flag C sets in that same cycle. The trigger fires at most once per arming, and flags A and B are frozen after it fires until the next arming.
- R9: With end_trig_i=1, disarm_o pulses together with trig_o and arm_o is 0 in that cycle. With end_trig_i=0, arm_o stays 1 and disarm_o stays 0.
- R10: Mode encodings 3 through 15 behave exactly as A only.
- R11: Match pulses in a cycle that has arm_set_i or arm_clr_i high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_en_i | input | 1 | Global debug enable |
| arm_set_i | input | 1 | Pulse: set the arm bit and clear the flags |
| arm_clr_i | input | 1 | Pulse: clear the arm bit |
| end_trig_i | input | 1 | 1: end-trigger (disarm on fire), 0: begin-trigger |
| mode_i | input | 4 | Trigger mode selector |
| match_a_i | input | 1 | Comparator A match pulse |
| match_b_i | input | 1 | Comparator B match pulse |
| arm_o | output | 1 | Arm bit |
| flag_a_o | output | 1 | Sticky flag A |
| flag_b_o | output | 1 | Sticky flag B |
| flag_c_o | output | 1 | Sticky flag: trigger has fired |
| trig_o | output | 1 | One-cycle trigger pulse |
| disarm_o | output | 1 | One-cycle disarm request (end-trigger) |

## Verification
The bench applies the following patterns:
- **B before A, with a gap before a later B:** distinguishes A then B from A or B.
- **A and B in the same cycle:** shows whether B is wrongly credited in the same cycle that A first matches.
- **Matches with enable low, with arm low, and in an arming cycle:** check the gating on arm, enable and the arming cycle.
- **Further matches after a fire:** confirm that the trigger fires once and that the flags freeze.
- **Both trigger-end settings:** tell disarm-on-fire apart from a held arm bit.
- **Reserved mode encodings:** driven with B-only pulses, which reveal any mode that is not falling back to A only.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int unsigned MODE_W    = 4;
  localparam int unsigned NUM_MODES = 9;
  localparam int unsigned NUM_CMP   = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_A_ONLY   = 4'd0,
    MODE_A_OR_B   = 4'd1,
    MODE_A_THEN_B = 4'd2
  } trig_mode_e;

  typedef struct packed {
    logic use_b;  // B comparator takes part
    logic seq;    // B only counts after A
  } mode_cfg_t;
endpackage

// File: rtl/dbg_mode_dec.sv
module dbg_mode_dec
  import dbg_trig_pkg::*;
#(
  parameter int unsigned MW = MODE_W,
  parameter int unsigned NM = NUM_MODES
) (
  input  logic [MW-1:0] mode_i,
  output mode_cfg_t     cfg_o
);
  localparam logic [MW-1:0] LAST_MODE = MW'(NM - 1);

  always_comb begin
    cfg_o = '{use_b: 1'b0, seq: 1'b0};
    if (mode_i <= LAST_MODE) begin
      unique case (mode_i)
        MW'(MODE_A_OR_B):   cfg_o = '{use_b: 1'b1, seq: 1'b0};
        MW'(MODE_A_THEN_B): cfg_o = '{use_b: 1'b1, seq: 1'b1};
        default:            cfg_o = '{use_b: 1'b0, seq: 1'b0};
      endcase
    end
  end
endmodule

// File: rtl/dbg_flag_bank.sv
module dbg_flag_bank #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[g] <= 1'b0;
      else if (clr_i)    q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/dbg_trig_ctrl.sv
module dbg_trig_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_go_i,
  input  logic arm_stop_i,
  input  logic fire_i,
  input  logic end_trig_i,
  output logic arm_o,
  output logic fired_o,
  output logic trig_o,
  output logic disarm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_o    <= 1'b0;
      fired_o  <= 1'b0;
      trig_o   <= 1'b0;
      disarm_o <= 1'b0;
    end else begin
      trig_o   <= 1'b0;
      disarm_o <= 1'b0;
      if (arm_stop_i) begin
        arm_o <= 1'b0;
      end else if (arm_go_i) begin
        arm_o   <= 1'b1;
        fired_o <= 1'b0;
      end else if (fire_i) begin
        trig_o  <= 1'b1;
        fired_o <= 1'b1;
        if (end_trig_i) begin
          arm_o    <= 1'b0;
          disarm_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_pkg::*;
#(
  parameter int unsigned MW = MODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dbg_en_i,
  input  logic          arm_set_i,
  input  logic          arm_clr_i,
  input  logic          end_trig_i,
  input  logic [MW-1:0] mode_i,
  input  logic          match_a_i,
  input  logic          match_b_i,
  output logic          arm_o,
  output logic          flag_a_o,
  output logic          flag_b_o,
  output logic          flag_c_o,
  output logic          trig_o,
  output logic          disarm_o
);
  localparam int unsigned IDX_A = 0;
  localparam int unsigned IDX_B = 1;

  mode_cfg_t          cfg;
  logic               arm_q, fired_q, arm_go, live, hit_a, hit_b, fire;
  logic [NUM_CMP-1:0] flags_q, flag_set;

  dbg_mode_dec #(.MW(MW), .NM(NUM_MODES)) u_dec (
    .mode_i (mode_i),
    .cfg_o  (cfg)
  );

  assign arm_go = arm_set_i & ~arm_clr_i;
  // no crediting in a cycle that touches the arm bit
  assign live   = arm_q & dbg_en_i & ~fired_q & ~arm_set_i & ~arm_clr_i;
  assign hit_a  = live & match_a_i;
  // same-cycle A does not qualify B: uses registered flag A
  assign hit_b  = live & match_b_i & cfg.use_b & (~cfg.seq | flags_q[IDX_A]);
  assign fire   = (hit_a & ~cfg.seq) | hit_b;

  always_comb begin
    flag_set        = '0;
    flag_set[IDX_A] = hit_a;
    flag_set[IDX_B] = hit_b;
  end

  dbg_flag_bank #(.N(NUM_CMP)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (arm_go),
    .set_i  (flag_set),
    .q_o    (flags_q)
  );

  dbg_trig_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_go_i   (arm_go),
    .arm_stop_i (arm_clr_i),
    .fire_i     (fire),
    .end_trig_i (end_trig_i),
    .arm_o      (arm_q),
    .fired_o    (fired_q),
    .trig_o     (trig_o),
    .disarm_o   (disarm_o)
  );

  assign arm_o    = arm_q;
  assign flag_a_o = flags_q[IDX_A];
  assign flag_b_o = flags_q[IDX_B];
  assign flag_c_o = fired_q;
endmodule

// File: rtl/dbg_trig_seq_chk.sv
module dbg_trig_seq_chk #(
  parameter int unsigned MW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dbg_en_i,
  input logic          arm_set_i,
  input logic          arm_clr_i,
  input logic          end_trig_i,
  input logic [MW-1:0] mode_i,
  input logic          match_a_i,
  input logic          match_b_i,
  input logic          arm_o,
  input logic          flag_a_o,
  input logic          flag_b_o,
  input logic          flag_c_o,
  input logic          trig_o,
  input logic          disarm_o
);
  p_arm_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_set_i && !arm_clr_i) |=> (arm_o && !flag_a_o && !flag_b_o && !flag_c_o));

  p_clr_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_clr_i |=> !arm_o);

  p_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_o || !dbg_en_i) |=> !trig_o);

  p_then_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_o && !flag_a_o && mode_i == MW'(2)) |=> !trig_o);

  p_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  p_flag_c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_c_o) |-> trig_o);

  p_disarm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disarm_o |-> (trig_o && !arm_o));

  p_arm_cycle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_set_i || arm_clr_i) |=> !trig_o);
endmodule

bind dbg_trig_seq dbg_trig_seq_chk #(.MW(MW)) u_chk (.*);

// File: tb/dbg_trig_seq_test.sv
module dbg_trig_seq_test;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic en = 0, aset = 0, aclr = 0, endm = 0, ma = 0, mb = 0;
  logic [3:0] mode = 0;
  logic arm, fa, fb, fc, trig, dis;

  int total = 0, bad = 0;
  string cur_req = "R1";

  // reference model state
  bit m_arm, m_fa, m_fb, m_fc, m_fired, m_trig, m_dis;

  always #(CLK_NS/2) clk = ~clk;

  dbg_trig_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .dbg_en_i(en), .arm_set_i(aset),
    .arm_clr_i(aclr), .end_trig_i(endm), .mode_i(mode),
    .match_a_i(ma), .match_b_i(mb), .arm_o(arm), .flag_a_o(fa),
    .flag_b_o(fb), .flag_c_o(fc), .trig_o(trig), .disarm_o(dis)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_arm, m_fa, m_fb, m_fc, m_fired, m_trig, m_dis} = '0;
    end else begin
      bit ha, hb, f;
      ha = 0; hb = 0; f = 0;
      m_trig = 0; m_dis = 0;
      if (aclr) m_arm = 0;
      else if (aset) begin
        m_arm = 1; m_fa = 0; m_fb = 0; m_fc = 0; m_fired = 0;
      end else if (m_arm && en && !m_fired) begin
        ha = ma;
        if (mode == 1) begin hb = mb; f = ma || mb; end
        else if (mode == 2) begin hb = mb && m_fa; f = hb; end
        else f = ma;
        if (ha) m_fa = 1;
        if (hb) m_fb = 1;
        if (f) begin
          m_trig = 1; m_fired = 1; m_fc = 1;
          if (endm) begin m_arm = 0; m_dis = 1; end
        end
      end
    end
  end

  task automatic chk(string name, logic act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", cur_req, name, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("arm_o", arm, m_arm);
    chk("flag_a_o", fa, m_fa);
    chk("flag_b_o", fb, m_fb);
    chk("flag_c_o", fc, m_fc);
    chk("trig_o", trig, m_trig);
    chk("disarm_o", dis, m_dis);
  end

  // one cycle of stimulus, driven after the falling edge
  task automatic cyc(bit a, bit b, bit s = 0, bit c = 0);
    @(negedge clk);
    ma = a; mb = b; aset = s; aclr = c;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0);
  endtask

  task automatic rearm();
    cyc(0, 0, 1, 0);
    cyc(0, 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 2 + 1);
    cur_req = "R1";
    chk("arm_o", arm, 0); chk("trig_o", trig, 0); chk("flag_c_o", fc, 0);
    @(negedge clk); rst_n = 1;
    idle(2);

    cur_req = "R3";              // not armed, enabled
    en = 1; cyc(1, 1); idle(2);
    en = 0; rearm();             // armed, disabled
    cyc(1, 0); cyc(0, 1); idle(2);

    cur_req = "R4"; en = 1; mode = 0; rearm();
    cyc(0, 1); idle(1); cyc(1, 0); idle(3);

    cur_req = "R8";              // further matches after the fire
    cyc(1, 0); cyc(1, 1); idle(2);

    cur_req = "R2";              // rearm clears flags, then clear wins
    rearm(); cyc(0, 0, 1, 1); idle(1); cyc(1, 0); idle(2);

    cur_req = "R5"; mode = 1; rearm();
    cyc(0, 1); idle(2);
    rearm(); cyc(1, 0); idle(2);

    cur_req = "R6"; mode = 2; rearm();
    cyc(0, 1); idle(1); cyc(1, 0); idle(2); cyc(0, 1); idle(3);

    cur_req = "R7"; rearm();
    cyc(1, 1); idle(2); cyc(0, 1); idle(2);

    cur_req = "R9"; endm = 1; mode = 1; rearm();
    cyc(0, 1); idle(3);
    endm = 0; rearm(); cyc(1, 0); idle(3);

    cur_req = "R10";
    for (int m = 3; m < 16; m++) begin
      mode = 4'(m); rearm();
      cyc(0, 1); idle(1); cyc(1, 0); idle(1);
    end

    cur_req = "R11"; mode = 1; endm = 0;
    cyc(1, 1, 1, 0); idle(2);
    cyc(1, 0, 0, 1); idle(2);

    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule